// File: doc/BRIEF.md
# Multi-Lane Structured Test Pattern Source

This block feeds a parallel multi-lane streaming link with a known test pattern. Each transfer is a set of 64-bit words, one per lane, offered together with a valid/ready handshake. Every word is a small record: the index of the lane it occupies, the number of the burst it belongs to, and the number of sets accepted before it. A checker at the far end can use these to confirm lane placement and ordering. Because all lanes of a set carry the same burst and set numbers, the checker can also confirm that the lanes were de-skewed correctly.

The source runs in one of two modes. In burst mode it groups sets into bursts of a programmable length and marks the first and last set of each burst. In continuous mode it sends an unbroken stream with no burst markers. An enable input starts and stops generation. A synchronous core reset from a control block restarts the counters and picks up a new mode and burst length.

Top module: `lane_pattern_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `src_valid` is low. The first set offered after reset carries set number 0 and burst number 1.
- R2: Lane i is carried on `src_data[64*i +: 64]`. Bits 63:59 of that word hold the value i, and this value never changes.
- R3: In any offered set, every lane carries the same bits 58:0.
- R4: Bits 31:0 hold the number of sets accepted since reset. A set is accepted in a cycle where `src_valid` and `src_ready` are both high, and the value steps by exactly one after each accepted set and at no other time.
- R5: Bits 58:32 hold the burst number. It is 1 after reset and rises by one on the set that follows the accepted last set of a burst.
- R6: In burst mode (`cont_mode` latched as 0), a burst is L sets long, where L is the latched `burst_len` and a value of 0 counts as 1. `src_sob` is high on the first set of each burst and `src_eob` is high on set L. When L is 1, both are high on every set.
- R7: In continuous mode (`cont_mode` latched as 1), `src_sob` and `src_eob` stay low and the burst number does not change.
- R8: Once `src_valid` is high, it stays high and `src_data` holds its value until the set is accepted, even if `enable` falls.
- R9: When no set is pending, `src_valid` follows `enable` one cycle later. After a pending set is accepted while `enable` is low, `src_valid` is low in the next cycle.
- R10: `cont_mode` and `burst_len` are sampled only while a reset is low. Changes to them at any other time have no effect on the output.
- R11: Holding `core_rst_n` low has the same effect as `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_rst_n | input | 1 | Synchronous active-low source reset from the control block |
| enable | input | 1 | Allows new sets to be offered |
| cont_mode | input | 1 | 1 selects continuous mode, 0 selects burst mode; sampled during reset |
| burst_len | input | LEN_W | Sets per burst, where 0 counts as 1; sampled during reset |
| src_ready | input | 1 | Sink accepts the offered set |
| src_valid | output | 1 | A set is offered |
| src_sob | output | 1 | First set of a burst |
| src_eob | output | 1 | Last set of a burst |
| src_data | output | 64*LANES | One 64-bit record per lane |

## Verification
A set counter that goes wrong shows at once in bits 31:0 of the next set offered. A stray or missing step is off by one in the very next accepted set, and a corrupted lane shows as a mismatch between lanes within that same set. An error in the burst position only shows at a burst edge: a misplaced start or end marker, or a burst number that changes at the wrong set, appears within L sets. A mode or length that leaks through outside reset changes the marker pattern within one burst.

// File: rtl/lpg_pkg.sv
// Shared field layout and the record builder for the lane pattern source.
// Assumes 64-bit lane words and no more than 32 lanes (5-bit lane index).
package lpg_pkg;
    localparam int LANE_WORD_W = 64;
    localparam int ID_W        = 5;
    localparam int BURST_W     = 27;
    localparam int COUNT_W     = 32;
    localparam int MAX_LANES   = 1 << ID_W;

    // Packs lane index, burst number and set number into one lane word.
    function automatic logic [LANE_WORD_W-1:0] make_word(
        input logic [ID_W-1:0]    lane_id,
        input logic [BURST_W-1:0] burst_no,
        input logic [COUNT_W-1:0] set_no
    );
        return {lane_id, burst_no, set_no};
    endfunction
endpackage

// File: rtl/lpg_seq_ctrl.sv
// Handshake and burst-position control.
// Holds the offered set until it is accepted, tracks the position inside a
// burst, and latches the mode and burst length while reset is low.
// Assumes the caller merges all reset sources into rst_all_n.
module lpg_seq_ctrl #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_all_n,
    input  logic             enable,
    input  logic             ready,
    input  logic             cont_mode_in,
    input  logic [LEN_W-1:0] burst_len_in,
    output logic             valid,
    output logic             accept,
    output logic             first_set,
    output logic             last_set,
    output logic             cont
);
    logic             valid_q;
    logic             cont_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] len_eff;

    // Effective burst length: a zero length counts as one.
    always_comb begin
        len_eff = (len_q == '0) ? LEN_W'(1) : len_q;
    end

    assign valid     = valid_q;
    assign accept    = valid_q && ready;
    assign cont      = cont_q;
    assign first_set = !cont_q && (pos_q == '0);
    assign last_set  = !cont_q && (pos_q == len_eff - LEN_W'(1));

    // Offer register, burst position and configuration latch.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            valid_q <= 1'b0;
            pos_q   <= '0;
            cont_q  <= cont_mode_in;
            len_q   <= burst_len_in;
        end else begin
            if (!valid_q || ready) begin
                valid_q <= enable;
            end
            if (accept && !cont_q) begin
                pos_q <= last_set ? '0 : pos_q + LEN_W'(1);
            end
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_all_n)
        valid_q && !ready |=> valid_q); // R8
    AST_POS_STILL: assert property (@(posedge clk) disable iff (!rst_all_n)
        !accept |=> $stable(pos_q)); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_all_n)
        1'b1 |=> $stable(cont_q) && $stable(len_q)); // R10
    AST_CONT_NO_MARK: assert property (@(posedge clk) disable iff (!rst_all_n)
        cont_q |-> !first_set && !last_set); // R7
endmodule

// File: rtl/lpg_counters.sv
// Set and burst counters shared by all lanes.
// The set counter steps on each accepted set. The burst counter steps after
// the last set of a burst is accepted, and only in burst mode.
// Reset puts them at 0 and 1.
module lpg_counters
    import lpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_all_n,
    input  logic               accept,
    input  logic               last_set,
    input  logic               cont,
    output logic [COUNT_W-1:0] set_no,
    output logic [BURST_W-1:0] burst_no
);
    // Counter update on accepted sets.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            set_no   <= '0;
            burst_no <= BURST_W'(1);
        end else if (accept) begin
            set_no <= set_no + COUNT_W'(1);
            if (last_set && !cont) begin
                burst_no <= burst_no + BURST_W'(1);
            end
        end
    end

    AST_SET_STEP: assert property (@(posedge clk) disable iff (!rst_all_n)
        accept |=> set_no == $past(set_no) + COUNT_W'(1)); // R4
    AST_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_all_n)
        !accept |=> $stable(set_no)); // R4
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_all_n)
        !(accept && last_set) |=> $stable(burst_no)); // R5
    AST_CONT_BURST: assert property (@(posedge clk) disable iff (!rst_all_n)
        cont |=> $stable(burst_no)); // R7
endmodule

// File: rtl/lpg_lane_pack.sv
// Builds one record per lane from the shared counters.
// Lane i gets index i in its top field. Assumes LANES is at most 32.
module lpg_lane_pack
    import lpg_pkg::*;
#(
    parameter int LANES = 6
) (
    input  logic [BURST_W-1:0]           burst_no,
    input  logic [COUNT_W-1:0]           set_no,
    output logic [LANES*LANE_WORD_W-1:0] data
);
    localparam int LANE_BITS = LANE_WORD_W;

    if (LANES > MAX_LANES || LANES < 1) begin : g_bad_lanes
        $error("lane count outside the range the index field can hold");
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Fixed lane index with the shared counters.
        assign data[i*LANE_BITS +: LANE_BITS] =
            make_word(ID_W'(i), burst_no, set_no);
    end
endmodule

// File: rtl/lane_pattern_gen.sv
// Multi-lane structured test pattern source.
// Offers one 64-bit record per lane on a valid/ready interface, with burst
// markers in burst mode. Both resets are synchronous and active low, and the
// mode and length are taken in while either reset is held.
module lane_pattern_gen
    import lpg_pkg::*;
#(
    parameter int LANES = 6,
    parameter int LEN_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         core_rst_n,
    input  logic                         enable,
    input  logic                         cont_mode,
    input  logic [LEN_W-1:0]             burst_len,
    input  logic                         src_ready,
    output logic                         src_valid,
    output logic                         src_sob,
    output logic                         src_eob,
    output logic [LANES*LANE_WORD_W-1:0] src_data
);
    logic               rst_all_n;
    logic               accept;
    logic               first_set;
    logic               last_set;
    logic               cont;
    logic [COUNT_W-1:0] set_no;
    logic [BURST_W-1:0] burst_no;

    assign rst_all_n = rst_n && core_rst_n;

    lpg_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst_all_n    (rst_all_n),
        .enable       (enable),
        .ready        (src_ready),
        .cont_mode_in (cont_mode),
        .burst_len_in (burst_len),
        .valid        (src_valid),
        .accept       (accept),
        .first_set    (first_set),
        .last_set     (last_set),
        .cont         (cont)
    );

    lpg_counters u_cnt (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .accept    (accept),
        .last_set  (last_set),
        .cont      (cont),
        .set_no    (set_no),
        .burst_no  (burst_no)
    );

    lpg_lane_pack #(.LANES(LANES)) u_pack (
        .burst_no (burst_no),
        .set_no   (set_no),
        .data     (src_data)
    );

    assign src_sob = src_valid && first_set;
    assign src_eob = src_valid && last_set;

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_all_n)
        src_valid && !src_ready |=> $stable(src_data)); // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_all_n |=> !src_valid); // R11
    AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_all_n)
        src_data[58:0] == src_data[(LANES-1)*LANE_WORD_W +: 59]); // R3
endmodule

// File: tb/lane_pattern_gen_tb.sv
// Self-checking bench: seeded random handshake and enable, with directed
// resets, mode changes and burst lengths, compared against a bench model.
module lane_pattern_gen_tb;
    localparam int  CLK_PERIOD = 10;
    localparam int  LANES      = 6;
    localparam int  LEN_W      = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  core_rst_n = 1'b1;
    logic                  enable = 1'b0;
    logic                  cont_mode = 1'b0;
    logic [LEN_W-1:0]      burst_len = '0;
    logic                  src_ready = 1'b0;
    logic                  src_valid;
    logic                  src_sob;
    logic                  src_eob;
    logic [LANES*64-1:0]   src_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit              m_valid;
    logic [31:0]     m_set;
    logic [26:0]     m_burst;
    int              m_pos;
    bit              m_cont;
    int              m_len;
    string           rst_tag = "R1";
    bit              after_rst = 1'b0;

    lane_pattern_gen #(.LANES(LANES), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .enable(enable),
        .cont_mode(cont_mode), .burst_len(burst_len), .src_ready(src_ready),
        .src_valid(src_valid), .src_sob(src_sob), .src_eob(src_eob),
        .src_data(src_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] exp_word(int lane, logic [26:0] b, logic [31:0] s);
        return {5'(lane), b, s};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Compare the outputs against the model. Called after a falling edge.
    task automatic compare(string ph);
        int le;
        check(after_rst ? rst_tag : {"R9 ", ph}, 64'(src_valid), 64'(m_valid));
        if (m_valid) begin
            le = (m_len == 0) ? 1 : m_len;
            if (after_rst) begin
                check({rst_tag, " set0"}, 64'(src_data[31:0]), 64'd0);
                check({rst_tag, " burst1"}, 64'(src_data[58:32]), 64'd1);
            end
            for (int i = 0; i < LANES; i++) begin
                check({"R2 ", ph}, 64'(src_data[i*64+59 +: 5]), 64'(i));
                check({"R4 ", ph}, 64'(src_data[i*64 +: 32]), 64'(m_set));
                check({m_cont ? "R7 " : "R5 ", ph}, 64'(src_data[i*64+32 +: 27]), 64'(m_burst));
                check({"R3 ", ph}, src_data[i*64 +: 64], exp_word(i, m_burst, m_set));
            end
            check({m_cont ? "R7 sob " : "R6 sob ", ph}, 64'(src_sob), 64'(!m_cont && m_pos == 0));
            check({m_cont ? "R7 eob " : "R6 eob ", ph}, 64'(src_eob), 64'(!m_cont && m_pos == le - 1));
            if (m_valid) after_rst = 1'b0;
        end
    endtask

    // One cycle: check, drive, advance model, wait for the next falling edge.
    task automatic step(string ph, bit r, bit cr, bit en, bit rdy, bit cm, int len);
        int  le;
        bit  hs;
        compare(ph);
        rst_n = r; core_rst_n = cr; enable = en; src_ready = rdy;
        cont_mode = cm; burst_len = LEN_W'(len);
        if (!r || !cr) begin
            m_valid = 0; m_set = 0; m_burst = 1; m_pos = 0;
            m_cont = cm; m_len = len;
            after_rst = 1'b1;
            rst_tag = !r ? "R1" : "R11";
        end else begin
            le = (m_len == 0) ? 1 : m_len;
            hs = m_valid && rdy;
            if (hs) begin
                m_set++;
                if (!m_cont) begin
                    if (m_pos == le - 1) begin m_pos = 0; m_burst++; end
                    else m_pos++;
                end
            end
            if (!m_valid || rdy) m_valid = en;
        end
        @(negedge clk);
    endtask

    task automatic run(string ph, int n, int p_en, int p_rdy, bit cm, int len, bit wild_cfg);
        for (int k = 0; k < n; k++) begin
            step(ph, 1, 1, $urandom_range(99) < p_en, $urandom_range(99) < p_rdy,
                 wild_cfg ? 1'($urandom_range(1)) : cm,
                 wild_cfg ? int'($urandom_range(7)) : len);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        m_valid = 0; m_set = 0; m_burst = 1; m_pos = 0; m_cont = 0; m_len = 3;
        @(negedge clk);
        // R1: reset held, burst mode, length 3
        for (int k = 0; k < 3; k++) step("R1", 0, 1, 1, 1, 0, 3);
        run("R6 L3", 300, 100, 70, 0, 3, 0);
        run("R8 en-toggle", 300, 50, 50, 0, 3, 0);
        // R10: config inputs wander without reset
        run("R10 cfg-ignored", 200, 90, 60, 0, 3, 1);
        // R11: core reset into continuous mode
        for (int k = 0; k < 2; k++) step("R11", 1, 0, 1, 1, 1, 4);
        run("R7 cont", 300, 80, 60, 1, 4, 0);
        for (int k = 0; k < 2; k++) step("R11", 1, 0, 0, 0, 0, 1);
        run("R6 L1", 200, 85, 65, 0, 1, 0);
        for (int k = 0; k < 2; k++) step("R1", 0, 1, 0, 0, 0, 0);
        run("R6 L0", 200, 85, 65, 0, 0, 0);
        for (int k = 0; k < 2; k++) step("R1", 0, 1, 1, 0, 0, 5);
        run("R6 L5", 100, 100, 100, 0, 5, 0);
        run("R9 stall", 20, 100, 0, 0, 5, 0);
        run("R9 drain", 20, 0, 100, 0, 5, 0);
        compare("end");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule